// File: doc/BRIEF.md
# Multi-mode general-purpose timer array

This block holds three identical timers behind one small synchronous register port. Each timer is set up through a 6-bit configuration register and three 32-bit registers (count, period, width). It runs in one of three modes: it can drive a periodic pulse train, measure the period and high time of a signal on its pin, or watch an external signal and raise an interrupt when enough edges arrive inside a time window. A shared control/status word starts and stops each timer on its own, latches one interrupt flag per timer (cleared by writing 1), and reports which timers are running.

Each timer's pin is brought out as three signals, `pin_out`, `pin_oe` and `pin_in`, for an external pad cell. The pin is driven only in waveform mode while the timer runs. In the other two modes it is sampled through a two-flop synchroniser. Period and width writes are held in shadow registers and copied into the working copies only at a period boundary, so a running waveform never emits a cut-short pulse.

Register word addresses: timer t uses 4t+0 for config, 4t+1 for count (read-only), 4t+2 for period and 4t+3 for width. Address 12 is the control/status word. Read data appears on `rdata` one clock after `rd_en`.

Top module: `gp_timer_array`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: The config register keeps only its low 6 bits. Writes to the count register are ignored.
- R3: Control bits [2:0] enable timers 0..2 separately, and status bits [10:8] read back the enables. While a timer is disabled its pin is not driven and its count reads 0.
- R4: In waveform mode (config[1:0]=01) the count runs 1..period and wraps to 1. The pin is active while count <= width, and `pin_oe` is 1. Config bit 2 = 0 makes active high; bit 2 = 1 makes active low.
- R5: When config bit 3 is set, each timer event sets status bit 4+t and `irq[t]` (the waveform event is the wrap). Writing 1 to bit 4+t clears the flag. With config bit 3 clear, no flag is set.
- R6: A period or width write to a running waveform timer takes effect only at the next wrap. Period and width reads return the written value in every mode except capture.
- R7: In capture mode (config[1:0]=10) the pin is not driven. The period register captures the clock cycles between active leading edges, and the width register captures the cycles from a leading edge to the following trailing edge.
- R8: In capture mode, config bit 4 = 0 raises the event on the leading edge and bit 4 = 1 raises it on the trailing edge.
- R9: In watchdog mode (config[1:0]=11) the count register counts active-going pin edges. When the count reaches the period value inside one window of width clock cycles, the event fires and the count restarts at 0.
- R10: In watchdog mode, if the window ends before the period is reached, the count restarts at 0 and no event fires.
- R11: Timers are independent: running one timer does not drive another timer's pin or change another timer's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data on rdata the next cycle |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 3 | Pad input level, one per timer |
| pin_out | output | 3 | Pad output level, one per timer |
| pin_oe | output | 3 | Pad output enable, one per timer |
| irq | output | 3 | Per-timer interrupt flags |

## Verification
The assertions assume that a timer's configuration is only rewritten while that timer is disabled. A mode switch while running would leave a capture-sized count inside a waveform period. They also assume that waveform periods are at least 1. The bench always disables a timer before changing its configuration. It holds every pin level for at least three clocks, so each level survives the synchroniser. Watchdog stimulus spaces edges clearly inside or clearly outside the window, so the expected outcome does not depend on the window phase.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    typedef enum logic [1:0] {
        GPT_OFF  = 2'b00,
        GPT_WAVE = 2'b01,
        GPT_CAPT = 2'b10,
        GPT_WDOG = 2'b11
    } gpt_mode_e;

    localparam int OFS_CFG = 0;
    localparam int OFS_CNT = 1;
    localparam int OFS_PER = 2;
    localparam int OFS_WID = 3;

    localparam int CFG_POL = 2;
    localparam int CFG_IRQ = 3;
    localparam int CFG_SEL = 4;

    localparam int CTL_FLAG_LSB = 4;
    localparam int CTL_RUN_LSB  = 8;
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CW      = 32,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  gpt_mode_e     mode,
    input  logic          pol,
    input  logic          irq_en,
    input  logic          sel_wid,
    input  logic          per_wr,
    input  logic          wid_wr,
    input  logic [CW-1:0] wdata,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          irq_evt,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] per_o,
    output logic [CW-1:0] wid_o,
    output logic [CW-1:0] per_act_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] win;
        logic [CW-1:0] per_act;
        logic [CW-1:0] wid_act;
        logic [CW-1:0] per_buf;
        logic [CW-1:0] wid_buf;
        logic          prev;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      pin_sync, lvl, lead, trail, wrap;
    logic [CW-1:0] edge_cnt;

    gpt_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    always_comb begin
        st_d     = st_q;
        irq_evt  = 1'b0;
        lvl      = pin_sync ^ pol;
        lead     = lvl & ~st_q.prev;
        trail    = ~lvl & st_q.prev;
        wrap     = (st_q.cnt != '0) && (st_q.cnt >= st_q.per_act);
        edge_cnt = st_q.cnt + CW'(lead);
        st_d.prev = lvl;

        if (per_wr) st_d.per_buf = wdata;
        if (wid_wr) st_d.wid_buf = wdata;

        if (!en) begin
            st_d.cnt     = '0;
            st_d.win     = '0;
            st_d.per_act = st_d.per_buf;
            st_d.wid_act = st_d.wid_buf;
        end else begin
            unique case (mode)
                GPT_WAVE: begin
                    if (wrap) begin
                        st_d.cnt     = CW'(1);
                        st_d.per_act = st_d.per_buf;
                        st_d.wid_act = st_d.wid_buf;
                        irq_evt      = irq_en;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                GPT_CAPT: begin
                    st_d.cnt = st_q.cnt + CW'(1);
                    if (lead) begin
                        st_d.per_act = st_q.cnt;
                        st_d.cnt     = CW'(1);
                        irq_evt      = irq_en & ~sel_wid;
                    end
                    if (trail) begin
                        st_d.wid_act = st_q.cnt;
                        irq_evt      = irq_en & sel_wid;
                    end
                end
                GPT_WDOG: begin
                    if (lead && (edge_cnt >= st_q.per_act)) begin
                        irq_evt      = irq_en;
                        st_d.cnt     = '0;
                        st_d.win     = '0;
                        st_d.per_act = st_d.per_buf;
                        st_d.wid_act = st_d.wid_buf;
                    end else if (st_q.win + CW'(1) >= st_q.wid_act) begin
                        st_d.cnt     = '0;
                        st_d.win     = '0;
                        st_d.per_act = st_d.per_buf;
                        st_d.wid_act = st_d.wid_buf;
                    end else begin
                        st_d.cnt = edge_cnt;
                        st_d.win = st_q.win + CW'(1);
                    end
                end
                default: begin
                    st_d.cnt = '0;
                    st_d.win = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_oe    = en && (mode == GPT_WAVE);
    assign pin_out   = ((st_q.cnt != '0) && (st_q.cnt <= st_q.wid_act)) ^ pol;
    assign cnt_o     = st_q.cnt;
    assign per_o     = (mode == GPT_CAPT) ? st_q.per_act : st_q.per_buf;
    assign wid_o     = (mode == GPT_CAPT) ? st_q.wid_act : st_q.wid_buf;
    assign per_act_o = st_q.per_act;
endmodule

// File: rtl/gp_timer_array.sv
module gp_timer_array
    import gpt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int CW      = 32,
    parameter int CFG_W   = 6,
    parameter int AW      = 4,
    parameter int SYNC_FF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [CW-1:0]      wdata,
    output logic [CW-1:0]      rdata,
    input  logic [NUM_TMR-1:0] pin_in,
    output logic [NUM_TMR-1:0] pin_out,
    output logic [NUM_TMR-1:0] pin_oe,
    output logic [NUM_TMR-1:0] irq
);
    localparam int CTRL_ADDR = NUM_TMR * 4;

    typedef struct packed {
        logic [NUM_TMR-1:0]            en;
        logic [NUM_TMR-1:0]            flag;
        logic [NUM_TMR-1:0][CFG_W-1:0] cfg;
        logic [CW-1:0]                 rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                        ctrl_hit;
    logic [NUM_TMR-1:0]          per_wr, wid_wr, irq_evt, clr, run;
    logic [NUM_TMR-1:0][CW-1:0]  cnt_w, per_w, wid_w, per_act_w;
    logic [NUM_TMR-1:0][1:0]     mode_w;
    logic [CW-1:0]               ctrl_rd;

    assign ctrl_hit = wr_en && (addr == AW'(CTRL_ADDR));
    assign clr      = ctrl_hit ? wdata[CTL_FLAG_LSB +: NUM_TMR] : '0;
    assign run      = st_q.en;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign per_wr[g] = wr_en && (addr == AW'(g * 4 + OFS_PER));
        assign wid_wr[g] = wr_en && (addr == AW'(g * 4 + OFS_WID));
        assign mode_w[g] = st_q.cfg[g][1:0];

        gpt_channel #(.CW(CW), .SYNC_FF(SYNC_FF)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (st_q.en[g]),
            .mode      (gpt_mode_e'(st_q.cfg[g][1:0])),
            .pol       (st_q.cfg[g][CFG_POL]),
            .irq_en    (st_q.cfg[g][CFG_IRQ]),
            .sel_wid   (st_q.cfg[g][CFG_SEL]),
            .per_wr    (per_wr[g]),
            .wid_wr    (wid_wr[g]),
            .wdata     (wdata),
            .pin_in    (pin_in[g]),
            .pin_out   (pin_out[g]),
            .pin_oe    (pin_oe[g]),
            .irq_evt   (irq_evt[g]),
            .cnt_o     (cnt_w[g]),
            .per_o     (per_w[g]),
            .wid_o     (wid_w[g]),
            .per_act_o (per_act_w[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        ctrl_rd = '0;
        ctrl_rd[NUM_TMR-1:0]              = st_q.en;
        ctrl_rd[CTL_FLAG_LSB +: NUM_TMR] = st_q.flag;
        ctrl_rd[CTL_RUN_LSB +: NUM_TMR]  = st_q.en;

        for (int i = 0; i < NUM_TMR; i++) begin
            if (wr_en && (addr == AW'(i * 4 + OFS_CFG))) st_d.cfg[i] = wdata[CFG_W-1:0];
        end
        if (ctrl_hit) st_d.en = wdata[NUM_TMR-1:0];
        st_d.flag = (st_q.flag & ~clr) | irq_evt;

        if (rd_en) begin
            st_d.rdata = '0;
            if (addr == AW'(CTRL_ADDR)) st_d.rdata = ctrl_rd;
            for (int i = 0; i < NUM_TMR; i++) begin
                if (addr[AW-1:2] == (AW-2)'(i)) begin
                    unique case (addr[1:0])
                        2'(OFS_CFG): st_d.rdata = CW'(st_q.cfg[i]);
                        2'(OFS_CNT): st_d.rdata = cnt_w[i];
                        2'(OFS_PER): st_d.rdata = per_w[i];
                        default:     st_d.rdata = wid_w[i];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = st_q.flag;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int NUM_TMR = 3,
    parameter int CW      = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_TMR-1:0]         run,
    input logic [NUM_TMR-1:0]         pin_oe,
    input logic [NUM_TMR-1:0]         irq,
    input logic [NUM_TMR-1:0]         irq_evt,
    input logic [NUM_TMR-1:0]         clr,
    input logic [NUM_TMR-1:0][1:0]    mode_w,
    input logic [NUM_TMR-1:0][CW-1:0] cnt_w,
    input logic [NUM_TMR-1:0][CW-1:0] per_act_w
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        assert_oe_only_wave_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] |-> (run[i] && mode_w[i] == 2'b01));

        assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && $past(!run[i])) |-> (cnt_w[i] == '0 && !pin_oe[i]));

        assert_wave_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && mode_w[i] == 2'b01 && $past(run[i] && mode_w[i] == 2'b01))
            |-> (cnt_w[i] <= per_act_w[i] || per_act_w[i] == '0));

        assert_irq_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(irq_evt[i]));

        assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !irq_evt[i]) |=> !irq[i]);
    end
endmodule

bind gp_timer_array gpt_checker #(.NUM_TMR(NUM_TMR), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .irq_evt   (irq_evt),
    .clr       (clr),
    .mode_w    (mode_w),
    .cnt_w     (cnt_w),
    .per_act_w (per_act_w)
);

// File: tb/gp_timer_array_tb.sv
module gp_timer_array_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  pin_in = '0;
    logic [2:0]  pin_out, pin_oe, irq;
    int checks = 0, errors = 0;

    gp_timer_array u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulses(input int idx, input int hi, input int lo, input int n);
        for (int k = 0; k < n; k++) begin
            pin_in[idx] = 1'b1; tick(hi);
            pin_in[idx] = 1'b0; tick(lo);
        end
    endtask

    task automatic align0(input logic pol);
        logic a, pa;
        pa = 1'b0;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            a = pin_out[0] ^ pol;
            if (a && !pa) break;
            pa = a;
        end
    endtask

    task automatic gap0(output int n);
        logic a, pa;
        n = 0;
        pa = pin_out[0];
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            n++;
            a = pin_out[0];
            if (a && !pa) break;
            pa = a;
        end
    endtask

    task automatic test_reset_R1();
        logic [31:0] d;
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a <= 12; a++) begin
            rd(4'(a), d);
            chk("R1 register reset", d, 0);
        end
    endtask

    task automatic test_regs_R2();
        logic [31:0] d;
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 cfg keeps 6 bits", d, 32'h3F);
        wr(0, 32'h0); wr(1, 32'h1234); rd(1, d); chk("R2 count write ignored", d, 0);
    endtask

    task automatic test_wave_R4(input logic pol);
        logic [31:0] d, c;
        int bad;
        logic a;
        c = 32'h1; c[2] = pol;
        wr(0, c); wr(2, 4); wr(3, 2); wr(12, 32'h1);
        align0(pol);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            a = pin_out[0] ^ pol;
            if (a !== ((k % 4) < 2)) bad++;
        end
        chk("R4 waveform pattern", bad, 0);
        chk("R4 pin driven", 32'(pin_oe[0]), 1);
        chk("R5 no flag when irq disabled", 32'(irq[0]), 0);
        wr(12, 32'h0); chk("R3 pin released on disable", 32'(pin_oe[0]), 0);
        tick(1); rd(1, d); chk("R3 count cleared on disable", d, 0);
    endtask

    task automatic test_irq_R5();
        logic [31:0] d;
        wr(0, 32'h9); wr(2, 3); wr(3, 1); wr(12, 32'h1);
        tick(10);
        chk("R5 irq set on wrap", 32'(irq[0]), 1);
        rd(12, d); chk("R5 status flag bit4", 32'(d[4]), 1);
        wr(12, 32'h0); wr(12, 32'h10);
        chk("R5 write-1 clears flag", 32'(irq[0]), 0);
        rd(12, d); chk("R5 status after clear", d, 0);
    endtask

    task automatic test_buffer_R6();
        logic [31:0] d;
        int n1, n2;
        wr(0, 32'h1); wr(2, 4); wr(3, 2); wr(12, 32'h1);
        align0(1'b0);
        wr(2, 6);
        gap0(n1); gap0(n2);
        chk("R6 current period unchanged", n1, 3);
        chk("R6 new period after wrap", n2, 6);
        rd(2, d); chk("R6 period readback", d, 6);
        wr(12, 32'h0);
    endtask

    task automatic test_capture_R7();
        logic [31:0] d;
        wr(4, 32'hA); wr(12, 32'h2); tick(2);
        pulses(1, 5, 7, 3); tick(4);
        chk("R7 pin not driven", 32'(pin_oe[1]), 0);
        rd(6, d); chk("R7 captured period", d, 12);
        rd(7, d); chk("R7 captured width", d, 5);
        wr(12, 32'h0); wr(12, 32'h70);
    endtask

    task automatic test_capsel_R8();
        wr(4, 32'h1A); wr(12, 32'h2); tick(4);
        pin_in[1] = 1'b1; tick(8);
        chk("R8 no event on leading edge (sel=1)", 32'(irq[1]), 0);
        pin_in[1] = 1'b0; tick(8);
        chk("R8 event on trailing edge (sel=1)", 32'(irq[1]), 1);
        wr(12, 32'h0); wr(12, 32'h70);
        wr(4, 32'hA); wr(12, 32'h2); tick(4);
        pin_in[1] = 1'b1; tick(8);
        chk("R8 event on leading edge (sel=0)", 32'(irq[1]), 1);
        pin_in[1] = 1'b0; tick(4);
        wr(12, 32'h0); wr(12, 32'h70);
    endtask

    task automatic test_wdog_R9();
        logic [31:0] d;
        wr(8, 32'hB); wr(10, 3); wr(11, 40); wr(12, 32'h4); tick(2);
        pulses(2, 3, 3, 3); tick(6);
        chk("R9 event when edges reach period", 32'(irq[2]), 1);
        rd(9, d); chk("R9 count restarts after event", d, 0);
        wr(12, 32'h0); wr(12, 32'h70);
    endtask

    task automatic test_wdog_R10();
        logic [31:0] d;
        wr(11, 10); wr(12, 32'h4); tick(2);
        pulses(2, 4, 4, 3); tick(12);
        chk("R10 no event when window expires", 32'(irq[2]), 0);
        rd(9, d); chk("R10 count reset by window", d, 0);
        wr(12, 32'h0);
    endtask

    task automatic test_indep_R11();
        logic [31:0] d;
        wr(0, 32'h1); wr(2, 5); wr(3, 2); wr(4, 32'h2); wr(8, 32'h1);
        wr(12, 32'h3); tick(7);
        rd(12, d); chk("R3 running bits", (d >> 8) & 32'h7, 32'h3);
        chk("R11 only timer0 drives", 32'(pin_oe), 32'h1);
        rd(9, d); chk("R11 idle timer count untouched", d, 0);
        wr(12, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        test_reset_R1();
        test_regs_R2();
        test_wave_R4(1'b0);
        test_wave_R4(1'b1);
        test_irq_R5();
        test_buffer_R6();
        test_capture_R7();
        test_capsel_R8();
        test_wdog_R9();
        test_wdog_R10();
        test_indep_R11();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule